// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a small 8-bit CPU core and decides which of five interrupt sources is taken next. The sources are two external inputs, two timer overflows and one serial port. Each raises a level flag that stays set until the block acknowledges it. Software loads a mask register and a level register through two write strobes. The mask register holds one global bit and one bit per source. The level register gives each source its own level, 0 (low) or 1 (high).

When a source may be served, the block raises a request to the CPU and presents that source's vector address. The CPU takes the request only at an instruction boundary. At that point the block sends a one-cycle acknowledge to the chosen source and marks its level as in service. Two in-service flags, one per level, control nesting. A high-level request may interrupt a low-level routine. A low-level request waits while any routine runs. A high-level request waits while another high-level routine runs. A return strobe from the CPU ends the innermost routine.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the mask register, the level register and both in-service flags are 0. As a result, irq_req stays low whatever the source flags are.
- R2: While the global mask bit is 0, irq_req stays low whatever the source flags and per-source mask bits are. The global bit is bit 5 of en_wdata.
- R3: Source numbering is external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. The source's bit in en_wdata[4:0], src_flag, src_ack and prio_wdata uses the same number. A source whose mask bit is 0 never raises irq_req.
- R4: Among eligible sources at the same level, the one with the lowest source number wins.
- R5: When eligible sources exist at both levels and the high level is not in service, a level-1 source (prio bit 1) wins over every level-0 source.
- R6: While irq_req is high, irq_vector equals 0x0003 + 8 x (winning source number). This gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R7: A request is taken only in a cycle where both irq_req and insn_boundary are high. In that same cycle, src_ack is one-hot on the winner. On the next clock, in_service[level of the winner] becomes 1. In any other cycle, src_ack is 0.
- R8: A level-0 source raises irq_req only while in_service is 2'b00. A level-1 source raises irq_req only while in_service[1] is 0. This applies even while a level-0 routine is in service.
- R9: A reti pulse clears in_service[1] on the next clock if that flag is set. Otherwise it clears in_service[0]. If a request is taken in the same cycle, its flag is set after the clear.
- R10: A write through en_wr/en_wdata or prio_wr/prio_wdata takes effect on the clock edge that ends the write cycle. It first affects irq_req in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the mask register |
| en_wdata | input | 6 | Mask data: bit 5 is the global bit, bits 4:0 are the per-source bits |
| prio_wr | input | 1 | Write strobe for the level register |
| prio_wdata | input | 5 | Level data, one bit per source (1 = high) |
| src_flag | input | 5 | Pending flags from the sources |
| insn_boundary | input | 1 | CPU is at an instruction boundary and may take a request |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Request to the CPU |
| irq_vector | output | 16 | Vector address of the winning source |
| src_ack | output | 5 | One-cycle acknowledge to the accepted source |
| in_service | output | 2 | In-service flags: bit 1 is high level, bit 0 is low level |

## Verification
irq_req, irq_vector and src_ack follow their inputs within the same cycle, with no register in between. They are therefore sampled 3 ns after the inputs change and before the next rising edge. The in-service flags and the configuration registers change one clock after the cycle that causes the change. The bench's behavioural model applies those updates at the rising edge and compares the model and the design again in the following cycle. In every cycle, the bench compares all four outputs against the model. Directed sequences cover masking, tie-breaks, level selection, nesting, returns that coincide with an accepted request, and late configuration writes. A random phase follows.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 5;
  localparam int LEVELS    = 2;
  localparam int VEC_W     = 16;
  localparam int VEC_BASE  = 3;
  localparam int VEC_STEP  = 8;

  // Vector address for a source number (polling order = numbering order).
  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    return VEC_W'(VEC_BASE + idx * VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N = irq_pkg::NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic [N:0]   en_wdata,
  input  logic         prio_wr,
  input  logic [N-1:0] prio_wdata,
  output logic         gen_q,
  output logic [N-1:0] en_q,
  output logic [N-1:0] prio_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      if (en_wr) begin
        gen_q <= en_wdata[N];
        en_q  <= en_wdata[N-1:0];
      end
      if (prio_wr) prio_q <= prio_wdata;
    end
  end

  // R10: registers only move on a write strobe
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q) && $stable(gen_q));
  assert_prio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_wr |=> $stable(prio_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = irq_pkg::NSRC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               flags,
  input  logic                       gen_q,
  input  logic [N-1:0]               en_q,
  input  logic [N-1:0]               prio_q,
  input  logic [1:0]                 ins,
  output logic                       req,
  output logic                       win_level,
  output logic [N-1:0]               win_onehot,
  output logic [irq_pkg::VEC_W-1:0]  vector
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] elig, hi_set, lo_set, pick;
  logic hi_ok, lo_ok;
  logic [IW-1:0] idx;

  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) if (v[k]) r = IW'(k);
    return r;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_src
    assign elig[i]   = flags[i] & en_q[i] & gen_q;
    assign hi_set[i] = elig[i] & prio_q[i];
    assign lo_set[i] = elig[i] & ~prio_q[i];
  end

  always_comb begin
    hi_ok      = (|hi_set) && !ins[1];
    lo_ok      = (|lo_set) && (ins == 2'b00);
    pick       = hi_ok ? hi_set : lo_set;
    idx        = lowest(pick);
    req        = hi_ok || lo_ok;
    win_level  = hi_ok;
    win_onehot = req ? (N'(1) << idx) : '0;
    vector     = irq_pkg::vec_of(int'(idx));
  end

  assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |-> !req);
  assert_hi_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ins[1] |-> !req);
  assert_lo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !win_level) |-> (ins == 2'b00));
  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $onehot(win_onehot & elig));
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_level,
  input  logic       reti,
  output logic [1:0] ins
);
  logic [1:0] clr_mask, set_mask;

  always_comb begin
    clr_mask = 2'b00;
    if (reti) clr_mask = ins[1] ? 2'b10 : 2'b01;
    set_mask = 2'b00;
    if (take) set_mask = take_level ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins <= 2'b00;
    else        ins <= (ins & ~clr_mask) | set_mask;
  end

  assert_reti_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && ins[1] && !(take && take_level)) |=> !ins[1]);
  assert_reti_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ins[1] && !take) |=> !ins[0]);
  assert_take_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_level) |=> ins[1]);
  assert_take_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_level) |=> ins[0]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N = irq_pkg::NSRC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_wr,
  input  logic [N:0]                en_wdata,
  input  logic                      prio_wr,
  input  logic [N-1:0]              prio_wdata,
  input  logic [N-1:0]              src_flag,
  input  logic                      insn_boundary,
  input  logic                      reti,
  output logic                      irq_req,
  output logic [irq_pkg::VEC_W-1:0] irq_vector,
  output logic [N-1:0]              src_ack,
  output logic [1:0]                in_service
);
  logic         gen_q;
  logic [N-1:0] en_q, prio_q, win_onehot;
  logic         win_level, take;

  irq_cfg_regs #(.N(N)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .prio_wr(prio_wr), .prio_wdata(prio_wdata),
    .gen_q(gen_q), .en_q(en_q), .prio_q(prio_q)
  );

  irq_arbiter #(.N(N)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .flags(src_flag), .gen_q(gen_q), .en_q(en_q), .prio_q(prio_q),
    .ins(in_service), .req(irq_req), .win_level(win_level),
    .win_onehot(win_onehot), .vector(irq_vector)
  );

  assign take    = irq_req && insn_boundary;
  assign src_ack = take ? win_onehot : '0;

  irq_nest_tracker u_nest (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_level(win_level), .reti(reti),
    .ins(in_service)
  );

  assert_ack_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ack) |-> (insn_boundary && irq_req));
  assert_ack_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ack) |-> ((src_ack & src_flag & en_q) == src_ack));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic en_wr, prio_wr, bnd, reti;
  logic [5:0] en_wd;
  logic [4:0] pr_wd, flags;
  logic irq_req;
  logic [15:0] irq_vector;
  logic [4:0] src_ack;
  logic [1:0] in_service;

  int checks = 0;
  int fails = 0;
  int m_gen;
  int m_en[5];
  int m_pr[5];
  int m_ins[2];

  always #4 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wd),
    .prio_wr(prio_wr), .prio_wdata(pr_wd), .src_flag(flags),
    .insn_boundary(bnd), .reti(reti), .irq_req(irq_req),
    .irq_vector(irq_vector), .src_ack(src_ack), .in_service(in_service)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: inputs already set after a falling edge.
  task automatic cycle(string tag);
    int w;
    int lvl;
    int exp_ack;
    #3;
    w = -1;
    lvl = 0;
    for (int L = 1; L >= 0; L--) begin
      if (w < 0 && !(L == 1 && m_ins[1] != 0) && !(L == 0 && (m_ins[1] != 0 || m_ins[0] != 0)))
        for (int s = 0; s < 5; s++)
          if (w < 0 && flags[s] && m_gen != 0 && m_en[s] != 0 && m_pr[s] == L) begin
            w = s;
            lvl = L;
          end
    end
    exp_ack = (bnd && w >= 0) ? (1 << w) : 0;
    chk(tag, "irq_req", int'(irq_req), (w >= 0) ? 1 : 0);
    if (w >= 0) chk("R6", "irq_vector", int'(irq_vector), 3 + 8 * w);
    chk("R7", "src_ack", int'(src_ack), exp_ack);
    chk("R9", "in_service", int'(in_service), m_ins[1] * 2 + m_ins[0]);
    @(posedge clk);
    if (rst_n) begin
      if (en_wr) begin
        m_gen = en_wd[5];
        for (int s = 0; s < 5; s++) m_en[s] = en_wd[s];
      end
      if (prio_wr) for (int s = 0; s < 5; s++) m_pr[s] = pr_wd[s];
      if (reti) begin
        if (m_ins[1] != 0) m_ins[1] = 0;
        else m_ins[0] = 0;
      end
      if (bnd && w >= 0) m_ins[lvl] = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    en_wr = 0; prio_wr = 0; bnd = 0; reti = 0;
  endtask

  task automatic wr_en(logic [5:0] v);
    idle_in(); en_wr = 1; en_wd = v; cycle("R10"); en_wr = 0;
  endtask

  task automatic wr_pr(logic [4:0] v);
    idle_in(); prio_wr = 1; pr_wd = v; cycle("R10"); prio_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_gen = 0; m_ins[0] = 0; m_ins[1] = 0;
    for (int s = 0; s < 5; s++) begin m_en[s] = 0; m_pr[s] = 0; end
    rst_n = 0; idle_in(); en_wd = 0; pr_wd = 0; flags = 5'b11111;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: nothing pending after reset even with all flags up
    cycle("R1"); bnd = 1; cycle("R1"); bnd = 0;
    // R2: per-source bits set, global off
    wr_en(6'b011111); bnd = 1; cycle("R2"); cycle("R2");
    // R10: enabling write; the write cycle itself still shows no request
    wr_en(6'b111111); cycle("R10");
    // R4: tie-break order
    flags = 5'b11110; cycle("R4");
    flags = 5'b11100; cycle("R4");
    flags = 5'b11000; cycle("R4");
    flags = 5'b10000; cycle("R6");
    // R3: serial masked off
    wr_en(6'b101111); flags = 5'b10000; cycle("R3"); bnd = 1; cycle("R3"); bnd = 0;
    wr_en(6'b111111);
    // R5: serial at high level beats all low sources
    wr_pr(5'b10000); flags = 5'b11111; cycle("R5");
    flags = 5'b01111; cycle("R5");
    // R8: nesting, ext1 high
    wr_pr(5'b00100);
    flags = 5'b00001; bnd = 1; cycle("R7");
    cycle("R8");
    flags = 5'b00010; cycle("R8");
    flags = 5'b00110; cycle("R8");
    cycle("R8");
    flags = 5'b00100; cycle("R8");
    bnd = 0; reti = 1; cycle("R9");
    cycle("R9");
    reti = 0; cycle("R9");
    // R9: reti coincident with a new take
    flags = 5'b00100; bnd = 1; cycle("R7");
    flags = 5'b00001; reti = 1; cycle("R9");
    reti = 0; bnd = 0; cycle("R9");
    reti = 1; cycle("R9");
    reti = 0; cycle("R9");
    // R2: global off again mid-run
    wr_en(6'b011111); flags = 5'b11111; bnd = 1; cycle("R2"); bnd = 0;
    // random phase
    for (int n = 0; n < 2000; n++) begin
      flags   = 5'($urandom);
      bnd     = ($urandom % 3) == 0;
      reti    = ($urandom % 5) == 0;
      en_wr   = ($urandom % 20) == 0;
      en_wd   = 6'($urandom) | 6'b100000;
      if (($urandom % 8) == 0) en_wd[5] = 1'b0;
      prio_wr = ($urandom % 20) == 0;
      pr_wd   = 5'($urandom);
      cycle("R8");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule